// File: doc/BRIEF.md
# Sawtooth Ramp Voice

A single audio voice that produces a stepped rising ramp. A 12-bit period divider counts down once per clock while the voice runs. Each time it passes zero it reloads from the programmed period and emits a carry. Every carry advances a fourteen-position step counter. On odd step positions a 6-bit rate is added into an 8-bit accumulator. After the last position, the accumulator and the step counter both return to zero. The upper five bits of the accumulator form the sample. The result is a seven-level staircase whose height is set by the rate and whose repeat time is set by the period.

Software-facing logic elsewhere writes three registers through a small write port: rate, period low byte, and period high nibble with enable. The frequency-mode input selects which part of the divider counts. A halt input freezes the voice.

A three-state controller governs the voice. The states are `VS_IDLE` (enable clear), `VS_RUN` (enabled, not halted) and `VS_PAUSE` (enabled, halted). The transitions are:
- enable-set: `VS_IDLE` to `VS_RUN` when halt is low, or to `VS_PAUSE` when halt is high.
- halt-rise: `VS_RUN` to `VS_PAUSE`.
- halt-fall: `VS_PAUSE` to `VS_RUN`.
- enable-clear: any state to `VS_IDLE`.

State changes follow the clock edge at which the causing write or halt level is sampled. The divider and the ramp advance only at edges that begin in `VS_RUN`.

Top module: `ramp_voice`

## Requirements
- R1: A write with select 0 loads the rate from data bits 5:0; data bits 7:6 have no effect.
- R2: Select 1 loads period bits 7:0 from the data byte. Select 2 loads period bits 11:8 from data bits 3:0 and the enable from data bit 7. After an enabling write following reset, the first carry occurs at the next clock edge.
- R3: On a carry, the rate is added to the accumulator only when the step counter holds an odd value before the carry; the step counter then increments.
- R4: A carry taken at step 13 returns both the accumulator and the step counter to 0. The output therefore repeats every 14 carries, which is 14×(P+1) clocks in normal mode.
- R5: The sample is accumulator bits 7:3 while the voice is in `VS_RUN`, and 0 otherwise.
- R6: With frequency mode 0, the whole 12-bit counter decrements, and a carry occurs when it is zero before the decrement, giving one carry every P+1 running clocks.
- R7: With frequency mode 1, counter bits 11:4 and bits 3:0 decrement independently, and a carry occurs when bits 11:4 are zero, giving one carry every period[11:4]+1 running clocks.
- R8: With frequency mode bit 1 set (modes 2 and 3), counter bits 11:8 and bits 7:0 decrement independently, and a carry occurs when bits 11:8 are zero, giving one carry every period[11:8]+1 running clocks.
- R9: A select-2 write with data bit 7 clear zeroes the accumulator.
- R10: Halt high at an edge stops the divider and ramp from the following edge on; the state is held and resumes unchanged once halt is low again.
- R11: Reset clears rate, period, enable, divider counter, step counter and accumulator.
- R12: The accumulator wraps modulo 256 when the rate sum overflows.
- R13: Writes with select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 rate, 1 period low, 2 period high and enable, 3 unused |
| wr_data | input | 8 | Write data byte |
| halt | input | 1 | Freeze the voice and silence the output |
| freq_mode | input | 2 | Divider mode: 0 full 12-bit, 1 upper 8 bits, 2 or 3 upper 4 bits |
| sample | output | 5 | Ramp sample, accumulator bits 7:3 |

## Verification
The assertions assume that a write and the halt level are each steady for a whole clock. They also assume that the frequency mode is changed only while the voice is idle or under reset, because a mode change in the middle of a countdown leaves the counter phase undefined for the bench's model. The stimulus drives every input on the falling edge. It selects the mode before enabling and resets the block at the start of each scenario. Period and rate are set before the enabling write, so the countdown always starts from a cleared counter.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    localparam int PERIOD_W = 12;
    localparam int RATE_W   = 6;
    localparam int ACC_W    = 8;
    localparam int SAMPLE_W = 5;
    localparam int NSTEPS   = 14;
    localparam int BYTE_W   = 8;

    typedef enum logic [1:0] {
        SEL_RATE = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_PHI  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        VS_IDLE  = 2'd0,
        VS_RUN   = 2'd1,
        VS_PAUSE = 2'd2
    } vstate_e;

endpackage

// File: rtl/ramp_regs.sv
module ramp_regs
    import ramp_pkg::*;
#(
    parameter int PER_W  = PERIOD_W,
    parameter int RT_W   = RATE_W,
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [RT_W-1:0]   rate_q,
    output logic [PER_W-1:0]  period_q,
    output logic              en_nxt,
    output logic              dis_pulse
);

    localparam int LO_W   = DATA_W;
    localparam int HI_W   = PER_W - DATA_W;
    localparam int EN_BIT = DATA_W - 1;

    logic [RT_W-1:0]  rate_d;
    logic [PER_W-1:0] per_d;
    logic             en_q;
    logic             en_d;

    always_comb begin
        rate_d = rate_q;
        per_d  = period_q;
        en_d   = en_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_RATE: rate_d = wr_data[RT_W-1:0];
                SEL_PLO:  per_d[LO_W-1:0] = wr_data;
                SEL_PHI: begin
                    per_d[PER_W-1:LO_W] = wr_data[HI_W-1:0];
                    en_d                = wr_data[EN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q   <= '0;
            period_q <= '0;
            en_q     <= 1'b0;
        end else begin
            rate_q   <= rate_d;
            period_q <= per_d;
            en_q     <= en_d;
        end
    end

    assign en_nxt    = en_d;
    assign dis_pulse = wr_en && (wr_sel == SEL_PHI) && !wr_data[EN_BIT];

    AST_SEL3_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_NONE) |=> ($stable(rate_q) && $stable(period_q) && $stable(en_q))); // R13

    AST_RATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_RATE) |=> (rate_q == $past(wr_data[RT_W-1:0]))); // R1

endmodule

// File: rtl/ramp_divider.sv
module ramp_divider
    import ramp_pkg::*;
#(
    parameter int PER_W = PERIOD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [PER_W-1:0] period,
    output logic             carry
);

    localparam int SH_NIB  = PER_W - 4;
    localparam int SH_BYTE = PER_W - 8;

    logic [PER_W-1:0]   cnt_q;
    logic [PER_W-1:0]   cnt_dec;
    logic [3:0]         nib_hi;
    logic [SH_NIB-1:0]  nib_lo;
    logic [7:0]         byte_hi;
    logic [SH_BYTE-1:0] byte_lo;
    logic               at_zero;

    always_comb begin
        nib_hi  = cnt_q[PER_W-1:SH_NIB] - 4'd1;
        nib_lo  = cnt_q[SH_NIB-1:0] - SH_NIB'(1);
        byte_hi = cnt_q[PER_W-1:SH_BYTE] - 8'd1;
        byte_lo = cnt_q[SH_BYTE-1:0] - SH_BYTE'(1);
        if (mode[1]) begin
            cnt_dec = {nib_hi, nib_lo};
            at_zero = (cnt_q[PER_W-1:SH_NIB] == 4'd0);
        end else if (mode[0]) begin
            cnt_dec = {byte_hi, byte_lo};
            at_zero = (cnt_q[PER_W-1:SH_BYTE] == 8'd0);
        end else begin
            cnt_dec = cnt_q - PER_W'(1);
            at_zero = (cnt_q == '0);
        end
    end

    assign carry = tick && at_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= carry ? period : cnt_dec;
        end
    end

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (cnt_q == $past(period))); // R6

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q)); // R10

    AST_NIB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !carry && mode[1]) |=> (cnt_q[PER_W-1:SH_NIB] == $past(cnt_q[PER_W-1:SH_NIB]) - 4'd1)); // R8

endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
    import ramp_pkg::*;
#(
    parameter int RT_W  = RATE_W,
    parameter int AC_W  = ACC_W,
    parameter int OUT_W = SAMPLE_W,
    parameter int STEPS = NSTEPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carry,
    input  logic             clear,
    input  logic [RT_W-1:0]  rate,
    output logic [OUT_W-1:0] level
);

    localparam int              STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

    logic [AC_W-1:0]   acc_q;
    logic [AC_W-1:0]   acc_d;
    logic [AC_W-1:0]   acc_sum;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_d;
    logic              at_last;

    assign acc_sum = acc_q + AC_W'(rate);
    assign at_last = (step_q == LAST);

    always_comb begin
        acc_d  = acc_q;
        step_d = step_q;
        if (carry) begin
            if (at_last) begin
                acc_d  = '0;
                step_d = '0;
            end else begin
                if (step_q[0]) begin
                    acc_d = acc_sum;
                end
                step_d = step_q + STEP_W'(1);
            end
        end
        if (clear) begin
            acc_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            step_q <= '0;
        end else begin
            acc_q  <= acc_d;
            step_q <= step_d;
        end
    end

    assign level = acc_q[AC_W-1:AC_W-OUT_W];

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST); // R4

    AST_ODD_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !clear && step_q[0] && !at_last) |=>
            (acc_q == $past(acc_q) + AC_W'($past(rate)))); // R3

    AST_EVEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !clear && !step_q[0]) |=> $stable(acc_q)); // R3

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && at_last) |=> (acc_q == '0 && step_q == '0)); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0)); // R9

endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
    import ramp_pkg::*;
#(
    parameter int OUT_W = SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_nxt,
    input  logic             halt,
    input  logic [OUT_W-1:0] level,
    output logic             tick,
    output logic [OUT_W-1:0] sample
);

    vstate_e state_q;
    vstate_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_IDLE: begin
                if (en_nxt) state_d = halt ? VS_PAUSE : VS_RUN;
            end
            VS_RUN: begin
                if (!en_nxt)   state_d = VS_IDLE;
                else if (halt) state_d = VS_PAUSE;
            end
            VS_PAUSE: begin
                if (!en_nxt)    state_d = VS_IDLE;
                else if (!halt) state_d = VS_RUN;
            end
            default: state_d = VS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        tick   = 1'b0;
        sample = '0;
        unique case (state_q)
            VS_RUN: begin
                tick   = 1'b1;
                sample = level;
            end
            default: ;
        endcase
    end

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !tick); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_nxt |=> (sample == '0)); // R5

endmodule

// File: rtl/ramp_voice.sv
module ramp_voice
    import ramp_pkg::*;
#(
    parameter int PER_W  = PERIOD_W,
    parameter int RT_W   = RATE_W,
    parameter int AC_W   = ACC_W,
    parameter int OUT_W  = SAMPLE_W,
    parameter int STEPS  = NSTEPS,
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              halt,
    input  logic [1:0]        freq_mode,
    output logic [OUT_W-1:0]  sample
);

    logic [RT_W-1:0]  rate_q;
    logic [PER_W-1:0] period_q;
    logic             en_nxt;
    logic             dis_pulse;
    logic             tick;
    logic             carry;
    logic [OUT_W-1:0] level;

    ramp_regs #(.PER_W(PER_W), .RT_W(RT_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rate_q    (rate_q),
        .period_q  (period_q),
        .en_nxt    (en_nxt),
        .dis_pulse (dis_pulse)
    );

    ramp_divider #(.PER_W(PER_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .mode   (freq_mode),
        .period (period_q),
        .carry  (carry)
    );

    ramp_seq #(.RT_W(RT_W), .AC_W(AC_W), .OUT_W(OUT_W), .STEPS(STEPS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .carry (carry),
        .clear (dis_pulse),
        .rate  (rate_q),
        .level (level)
    );

    ramp_ctrl #(.OUT_W(OUT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_nxt (en_nxt),
        .halt   (halt),
        .level  (level),
        .tick   (tick),
        .sample (sample)
    );

    AST_CARRY_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> tick); // R5

endmodule

// File: tb/ramp_voice_bench.sv
`timescale 1ns/1ps
module ramp_voice_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       halt = 1'b0;
    logic [1:0] freq_mode = 2'd0;
    logic [4:0] sample;

    int n_chk = 0;
    int n_err = 0;

    int m_ticks = 0;
    bit m_run = 1'b0;
    bit m_en = 1'b0;
    int m_intv = 1;
    int m_rate = 0;

    always #10 clk = ~clk;

    ramp_voice u_ramp_voice (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .halt      (halt),
        .freq_mode (freq_mode),
        .sample    (sample)
    );

    // Expected-behaviour tracker built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ticks = 0;
            m_run   = 1'b0;
        end else begin
            if (m_run) m_ticks++;
            m_run = m_en && !halt;
        end
    end

    function automatic int exp_out();
        int c, j, lvl;
        if (!m_run || m_ticks == 0) return 0;
        c   = (m_ticks - 1) / m_intv + 1;
        j   = (c - 1) % 14;
        lvl = (j == 13) ? 0 : ((j + 1) / 2) * m_rate;
        return (lvl % 256) / 8;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        wr_en  = 1'b0;
        halt   = 1'b0;
        m_en   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        if (sel == 2'd2) m_en = data[7];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_chk(input int n, input string req);
        repeat (n) begin
            @(negedge clk);
            chk(req, int'(sample), exp_out());
        end
    endtask

    task automatic setup(input logic [1:0] mode, input logic [7:0] rate_byte,
                         input logic [11:0] per, input int intv, input int rate_eff);
        do_reset();
        freq_mode = mode;
        m_intv    = intv;
        m_rate    = rate_eff;
        wr(2'd0, rate_byte);
        wr(2'd1, per[7:0]);
        wr(2'd2, {4'h8, per[11:8]});
    endtask

    task automatic t_reset();
        setup(2'd0, 8'd40, 12'd2, 3, 40);
        run_chk(20, "R5");
        do_reset();
        chk("R11", int'(sample), 0);
        m_intv = 1;
        m_rate = 0;
        wr(2'd2, 8'h80);          // enable only, rate left at its reset value
        run_chk(30, "R11");
    endtask

    task automatic t_ramp_period();
        int hist[56];
        setup(2'd0, 8'd8, 12'd3, 4, 8);
        run_chk(56, "R3,R6");
        for (int i = 0; i < 56; i++) begin
            @(negedge clk);
            hist[i] = int'(sample);
            chk("R3,R5", int'(sample), exp_out());
        end
        for (int i = 0; i < 56; i++) begin
            @(negedge clk);
            chk("R4", int'(sample), hist[i]);
        end
    endtask

    task automatic t_rate_mask();
        setup(2'd0, 8'hC8, 12'd1, 2, 8);
        run_chk(40, "R1");
    endtask

    task automatic t_wrap();
        setup(2'd0, 8'h3F, 12'd0, 1, 63);
        run_chk(30, "R12");
    endtask

    task automatic t_byte_mode();
        setup(2'd1, 8'd16, 12'h025, 3, 16);
        run_chk(60, "R7");
    endtask

    task automatic t_nib_mode();
        setup(2'd2, 8'd16, 12'h2FF, 3, 16);
        run_chk(60, "R8");
        setup(2'd3, 8'd24, 12'h1AB, 2, 24);
        run_chk(40, "R8");
    endtask

    task automatic t_long_period();
        setup(2'd0, 8'd8, 12'h105, 262, 8);
        run_chk(3700, "R2");
    endtask

    task automatic t_halt();
        setup(2'd0, 8'd24, 12'd2, 3, 24);
        run_chk(10, "R10");
        @(negedge clk);
        halt = 1'b1;
        run_chk(20, "R5,R10");
        halt = 1'b0;
        run_chk(45, "R10");
    endtask

    task automatic t_disable();
        setup(2'd0, 8'd32, 12'd1, 2, 32);
        for (int i = 0; i < 20; i++) begin
            if (exp_out() != 0) break;
            @(negedge clk);
        end
        chk("R9", int'(sample != 5'd0), 1);
        wr(2'd2, 8'h01);
        run_chk(5, "R5");
        wr(2'd2, 8'h81);
        chk("R9", int'(sample), 0);
    endtask

    task automatic t_sel_unused();
        setup(2'd0, 8'd8, 12'd3, 4, 8);
        run_chk(20, "R13");
        wr(2'd3, 8'hFF);
        run_chk(60, "R13");
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_ramp_period();
        t_rate_mask();
        t_wrap();
        t_byte_mode();
        t_nib_mode();
        t_long_period();
        t_halt();
        t_disable();
        t_sel_unused();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule